// File: doc/BRIEF.md
# FIFO-Buffered Synchronous Serial Transceiver

This block moves 8-bit words over a full-duplex clocked serial link. Software places outgoing words in a 16-entry transmit queue and collects incoming words from a 16-entry receive queue, all through a four-register byte interface. The block drives the serial clock itself, at the system clock divided by a fixed parameter. For every word it shifts one word out on `sdo` and one word in from `sdi`. Both directions run from a single run state, which only a write that sets both enable bits at once can turn on.

Two threshold flags tell software when to act. One reports that the transmit queue has drained to a programmable level. The other reports that the receive queue has filled to a programmable level. A third flag records receive overrun. All three flags are sticky, and software clears one only by reading it as 1 and then writing 0 to it. Each direction has an interrupt enable that gates its flags onto an interrupt pin.

The data register is the only path for words. Back-pressure is not signalled per word. A write to the data register while the transmit queue is full is dropped, and a read while the receive queue is empty returns a stale word and changes nothing. Software is expected to pace itself by the threshold flags. On the serial side, the link stalls at a word boundary while the transmit queue is empty.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, the mode and queue-control registers read 0, status reads 0x01 (only the transmit-low flag, once the first cycle has passed), both interrupt pins are low and `sclk` is low.
- R2: Status bit 0 (transmit-low) becomes set whenever the transmit queue holds at most the threshold chosen by queue-control bits [3:2]: 00 = 8, 01 = 4, 10 = 2, 11 = 0 entries.
- R3: Status bit 1 (receive-hit) becomes set whenever the receive queue holds at least the threshold chosen by queue-control bits [1:0]: 00 = 1, 01 = 4, 10 = 8, 11 = 14 entries.
- R4: A status flag clears only when status is written with a 0 in that bit position and a status read since the previous status write returned that bit as 1. Any status write drops all read records. A flag whose setting condition still holds stays at 1.
- R5: While queue-control bit 4 (transmit) or bit 5 (receive) is 1, that queue is held empty and words pushed into it are lost.
- R6: A mode-register write with bits [1:0] = 11 starts the link, shown as mode bit 4. A write with bits [1:0] = 00 stops it after the word in flight. A write with only one of the two bits set neither starts nor stops the link.
- R7: Each word takes eight `sclk` periods of 2*DIV system clocks, low phase first. `sdo` is stable at each rising `sclk`, where `sdi` is sampled. Words go MSB first, or LSB first when queue-control bit 6 is 1.
- R8: With the link running and the transmit queue empty, `sclk` stays low after the current word, and the link resumes when a word is written.
- R9: A word that completes while the receive queue is full is discarded, and status bit 2 (overrun) is set. This flag is cleared the same way as the others.
- R10: `tx_irq` equals transmit-low AND mode bit 2. `rx_irq` equals (receive-hit OR overrun) AND mode bit 3.
- R11: Writing address 3 pushes a word into the transmit queue. Reading address 3 returns the oldest received word and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 2 | 0 mode, 1 queue control, 2 status, 3 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong queue count shows at the ports within one cycle as a threshold flag that sets too early or too late, and it shows as a wrong word returned by the data register. A shift or phase fault in the serial engine shows on the next word as a loopback mismatch or a wrong bit order. A stray start, or a missing stall, shows as `sclk` edges that come before the enable write or after the queue has emptied. A broken read-then-clear record shows on the next status write, either as a flag that clears without having been read or as a flag that cannot be cleared.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;
  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_QCTL = 2'd1,
    A_STAT = 2'd2,
    A_DATA = 2'd3
  } sst_addr_e;

  localparam int B_TLOW = 0;
  localparam int B_RHIT = 1;
  localparam int B_OVR  = 2;
endpackage

// File: rtl/sst_fifo.sv
`timescale 1ns/1ps
module sst_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sst_engine.sv
`timescale 1ns/1ps
module sst_engine #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       lsb_first,
  input  logic       tx_avail,
  input  logic [7:0] tx_data,
  output logic       tx_pop,
  output logic       rx_push,
  output logic [7:0] rx_data,
  output logic       sclk,
  output logic       sdo,
  input  logic       sdi,
  output logic       busy
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt;
  logic          phase;
  logic [2:0]    bitn;
  logic [7:0]    tsr, rsr;
  logic          start, half_end;

  assign start    = !busy && run && tx_avail;
  assign half_end = busy && (cnt == DW'(DIV-1));
  assign tx_pop   = start;
  assign rx_push  = half_end && phase && (bitn == 3'd7);
  assign rx_data  = rsr;
  assign sdo      = lsb_first ? tsr[0] : tsr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; sclk <= 1'b0;
      cnt <= '0; bitn <= '0; tsr <= '0; rsr <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; tsr <= tx_data; cnt <= '0; phase <= 1'b0; bitn <= '0;
      end
    end else if (half_end) begin
      cnt <= '0;
      if (!phase) begin
        phase <= 1'b1;
        sclk  <= 1'b1;
        rsr   <= lsb_first ? {sdi, rsr[7:1]} : {rsr[6:0], sdi};
      end else begin
        phase <= 1'b0;
        sclk  <= 1'b0;
        if (bitn == 3'd7) begin
          busy <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
          tsr  <= lsb_first ? {1'b0, tsr[7:1]} : {tsr[6:0], 1'b0};
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
module sync_serial_xcvr
  import sst_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_irq,
  output logic       rx_irq,
  output logic       sclk,
  output logic       sdo,
  input  logic       sdi
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          run_q, tie_q, rie_q, trst_q, rrst_q, lsb_q;
  logic [1:0]    en_q, rtrg_q, ttrg_q;
  logic          tlow, rhit, ovr;
  logic [2:0]    arm_q, flags, set_v, clr_v;
  logic          wr_mode, wr_qctl, wr_stat, wr_data, rd_stat, rd_data;
  logic [CW-1:0] txf_cnt, rxf_cnt, thr_t, thr_r;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]    tx_head, rx_head, rx_word;
  logic          tx_pop, rx_push, busy;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_qctl = reg_wr && (reg_addr == A_QCTL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);
  assign rd_data = reg_rd && (reg_addr == A_DATA);

  sst_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(trst_q), .push(wr_data && !tx_full),
    .din(reg_wdata), .pop(tx_pop), .dout(tx_head), .count(txf_cnt),
    .full(tx_full), .empty(tx_empty));

  sst_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rrst_q), .push(rx_push),
    .din(rx_word), .pop(rd_data && !rx_empty), .dout(rx_head), .count(rxf_cnt),
    .full(rx_full), .empty(rx_empty));

  sst_engine #(.DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run_q), .lsb_first(lsb_q),
    .tx_avail(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_word), .sclk(sclk), .sdo(sdo),
    .sdi(sdi), .busy(busy));

  always_comb begin
    case (ttrg_q)
      2'b00:   thr_t = CW'(8);
      2'b01:   thr_t = CW'(4);
      2'b10:   thr_t = CW'(2);
      default: thr_t = CW'(0);
    endcase
    case (rtrg_q)
      2'b00:   thr_r = CW'(1);
      2'b01:   thr_r = CW'(4);
      2'b10:   thr_r = CW'(8);
      default: thr_r = CW'(14);
    endcase
  end

  assign flags         = {ovr, rhit, tlow};
  assign set_v[B_TLOW] = (txf_cnt <= thr_t);
  assign set_v[B_RHIT] = (rxf_cnt >= thr_r);
  assign set_v[B_OVR]  = rx_push && rx_full;
  assign clr_v         = {3{wr_stat}} & ~reg_wdata[2:0] & arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; en_q <= '0; tie_q <= 1'b0; rie_q <= 1'b0;
      rtrg_q <= '0; ttrg_q <= '0; trst_q <= 1'b0; rrst_q <= 1'b0; lsb_q <= 1'b0;
      {ovr, rhit, tlow} <= '0;
      arm_q <= '0;
    end else begin
      if (wr_mode) begin
        en_q  <= reg_wdata[1:0];
        tie_q <= reg_wdata[2];
        rie_q <= reg_wdata[3];
        if (reg_wdata[1:0] == 2'b11)      run_q <= 1'b1;
        else if (reg_wdata[1:0] == 2'b00) run_q <= 1'b0;
      end
      if (wr_qctl) begin
        rtrg_q <= reg_wdata[1:0];
        ttrg_q <= reg_wdata[3:2];
        trst_q <= reg_wdata[4];
        rrst_q <= reg_wdata[5];
        lsb_q  <= reg_wdata[6];
      end
      {ovr, rhit, tlow} <= set_v | (flags & ~clr_v);
      if (wr_stat)      arm_q <= '0;
      else if (rd_stat) arm_q <= arm_q | flags;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {3'b000, run_q, rie_q, tie_q, en_q};
      A_QCTL:  reg_rdata = {1'b0, lsb_q, rrst_q, trst_q, ttrg_q, rtrg_q};
      A_STAT:  reg_rdata = {5'b00000, flags};
      default: reg_rdata = rx_head;
    endcase
  end

  assign tx_irq = tlow && tie_q;
  assign rx_irq = (rhit || ovr) && rie_q;
endmodule

// File: rtl/sst_checker.sv
`timescale 1ns/1ps
module sst_checker
  import sst_pkg::*;
#(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          wd0,
  input logic          tlow,
  input logic          rhit,
  input logic          ovr,
  input logic [CW-1:0] txf_cnt,
  input logic [CW-1:0] rxf_cnt,
  input logic [CW-1:0] thr_t,
  input logic [CW-1:0] thr_r,
  input logic          rx_full,
  input logic          sclk,
  input logic          busy,
  input logic          trst
);
  assert_tx_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_cnt <= thr_t) |=> tlow);

  assert_rx_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_cnt >= thr_r) |=> rhit);

  assert_tx_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tlow) |-> $past(reg_wr && (reg_addr == A_STAT) && !wd0));

  assert_hold_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trst) |-> (txf_cnt == '0));

  assert_sclk_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(busy));

  assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full));

  assert_rx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_cnt <= CW'(DEPTH));
endmodule

bind sync_serial_xcvr sst_checker #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd0(reg_wdata[0]), .tlow(tlow), .rhit(rhit), .ovr(ovr),
  .txf_cnt(txf_cnt), .rxf_cnt(rxf_cnt), .thr_t(thr_t), .thr_r(thr_r),
  .rx_full(rx_full), .sclk(sclk), .busy(busy), .trst(trst_q));

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  import sst_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tx_irq, rx_irq, sclk, sdo, sdi;
  int         total = 0, bad = 0, rises = 0;
  logic [7:0] mon = 8'd0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;
  assign sdi = sdo;

  sync_serial_xcvr #(.DEPTH(16), .DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk(sclk), .sdo(sdo), .sdi(sdi));

  always @(posedge sclk) begin
    rises <= rises + 1;
    mon   <= {mon[6:0], sdo};
  end

  // {lsb_first, word, expected bit capture}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hC1, 8'hC1}, {1'b1, 8'hC1, 8'h83}, {1'b0, 8'h01, 8'h01},
    {1'b1, 8'h01, 8'h80}, {1'b1, 8'h12, 8'h48}, {1'b0, 8'h12, 8'h12}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r0;
    idle(3); rst_n = 1'b1; idle(3);

    // R1 reset state
    chk("R1 sclk idle", sclk, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rx_irq", rx_irq, 0);
    rd(A_MODE, v); chk("R1 mode", v, 8'h00);
    rd(A_QCTL, v); chk("R1 qctl", v, 8'h00);
    rd(A_STAT, v); chk("R1 status", v, 8'h01);

    // R4 write-0 without a fresh read leaves the flag; R2 9 entries > 8
    wr(A_STAT, 8'hFF);
    for (int i = 0; i < 9; i++) wr(A_DATA, 8'(i));
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R4 unarmed write keeps flag", v & 1, 1);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R2 R4 armed clear above threshold", v & 1, 0);

    // R5 reset held: push lost, threshold 0 keeps flag set
    wr(A_QCTL, 8'h1C);
    wr(A_DATA, 8'h77);
    wr(A_QCTL, 8'h0C);
    rd(A_STAT, v); wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R5 held queue stays empty", v & 1, 1);
    wr(A_QCTL, 8'h00);

    // R6 separate enable writes do not start
    r0 = rises;
    wr(A_DATA, 8'h5A);
    wr(A_MODE, 8'h01); wr(A_MODE, 8'h02);
    idle(100);
    chk("R6 no start on split enables", rises - r0, 0);
    rd(A_MODE, v); chk("R6 run bit clear", (v >> 4) & 1, 0);
    wr(A_MODE, 8'h03);
    idle(100);
    chk("R6 start on joint enables", rises - r0, 8);
    rd(A_MODE, v); chk("R6 run bit set", (v >> 4) & 1, 1);
    rd(A_DATA, v); chk("R11 first loopback word", v, 8'h5A);

    // R8 stall on empty queue, resume on write
    idle(200);
    chk("R8 clock stopped", rises - r0, 8);
    chk("R8 sclk low while stalled", sclk, 0);
    wr(A_DATA, 8'h33);
    idle(100);
    chk("R8 clock resumed", rises - r0, 16);
    rd(A_DATA, v); chk("R11 resumed word", v, 8'h33);

    // R6 stop takes effect after the word in flight
    wr(A_MODE, 8'h00);
    r0 = rises;
    wr(A_DATA, 8'hA1); wr(A_DATA, 8'hA2);
    wr(A_MODE, 8'h03);
    idle(20);
    wr(A_MODE, 8'h00);
    idle(200);
    chk("R6 stop after current word", rises - r0, 8);
    rd(A_DATA, v); chk("R11 word before stop", v, 8'hA1);
    wr(A_QCTL, 8'h10); wr(A_QCTL, 8'h00);

    // R7 R11 table of words and bit orders
    wr(A_MODE, 8'h03);
    for (int i = 0; i < 6; i++) begin
      wr(A_QCTL, {1'b0, VEC[i][16], 6'b0});
      r0 = rises;
      wr(A_DATA, VEC[i][15:8]);
      idle(90);
      chk("R7 eight clocks per word", rises - r0, 8);
      chk("R7 bit order on sdo", mon, VEC[i][7:0]);
      rd(A_DATA, v); chk("R11 table loopback", v, VEC[i][15:8]);
    end

    // R3 receive threshold 4, R10 rx gating
    wr(A_QCTL, 8'h01);
    rd(A_STAT, v); wr(A_STAT, 8'h00);
    for (int i = 0; i < 3; i++) wr(A_DATA, 8'(8'h40 + i));
    idle(230);
    rd(A_STAT, v); chk("R3 three below threshold", (v >> 1) & 1, 0);
    wr(A_DATA, 8'h43);
    idle(90);
    rd(A_STAT, v); chk("R3 four reaches threshold", (v >> 1) & 1, 1);
    chk("R10 rx_irq masked", rx_irq, 0);
    wr(A_MODE, 8'h0B);
    chk("R10 rx_irq enabled", rx_irq, 1);
    for (int i = 0; i < 4; i++) begin
      rd(A_DATA, v); chk("R11 queued order", v, 8'h40 + i);
    end

    // R2 transmit threshold 4, R10 tx gating
    wr(A_MODE, 8'h00);
    wr(A_QCTL, 8'h15); wr(A_QCTL, 8'h05);
    for (int i = 0; i < 4; i++) wr(A_DATA, 8'(i));
    rd(A_STAT, v); wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R2 four at threshold stays", v & 1, 1);
    wr(A_DATA, 8'h04);
    rd(A_STAT, v); wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R2 five above threshold clears", v & 1, 0);
    wr(A_MODE, 8'h04);
    chk("R10 tx_irq low without flag", tx_irq, 0);
    wr(A_QCTL, 8'h15); wr(A_QCTL, 8'h05);
    chk("R10 tx_irq with flag", tx_irq, 1);

    // R9 overrun
    wr(A_MODE, 8'h00);
    wr(A_QCTL, 8'h15); wr(A_QCTL, 8'h05);
    rd(A_STAT, v); wr(A_STAT, 8'h00);
    for (int i = 0; i < 16; i++) wr(A_DATA, 8'(i));
    wr(A_MODE, 8'h0B);
    idle(16 * 66 + 60);
    rd(A_STAT, v); chk("R9 no overrun at exactly full", (v >> 2) & 1, 0);
    wr(A_DATA, 8'hEE);
    idle(100);
    rd(A_STAT, v); chk("R9 overrun set", (v >> 2) & 1, 1);
    chk("R9 R10 rx_irq on overrun", rx_irq, 1);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, v); chk("R9 kept words intact", v, i);
    end
    wr(A_MODE, 8'h00);
    rd(A_STAT, v); wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R9 overrun cleared", (v >> 2) & 1, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule